// File: doc/BRIEF.md
# Bus-Mapped Multiply-Accumulate Unit

This block is a 16x16 multiplier that sits on a simple synchronous register bus. Software picks the arithmetic style by choosing which of four operand-1 addresses it writes: unsigned product, signed product, unsigned running sum or signed running sum. The write of operand 2 then performs the chosen operation in the clock edge that takes the write. The outcome is read back as a low word, a high word and a sum-extension word.

In the two running-sum styles each new product is added to an accumulator, and the result words mirror that accumulator. Software can seed the accumulator by writing the low result word. The signed accumulator is kept wider than the 32-bit result, so the sum-extension word keeps the true sign of a signed running sum that has overflowed 32 bits.

All accesses are 16-bit words. Read data is combinational from the current address and the registered state. A write changes the state at the rising edge that samples it, and the new value can be read from the next cycle on.

Top module: `mpy_mac_periph`

## Requirements
- R1: After reset, every offset of the window reads 0. This covers the low result (BASE+0xA), the high result (BASE+0xC) and the sum extension (BASE+0xE).
- R2: A write to BASE+0x0, 0x2, 0x4 or 0x6 stores operand 1. The offset also selects the mode, in that order: unsigned multiply, signed multiply, unsigned accumulate, signed accumulate.
- R3: Only a write to BASE+0x8 (operand 2) performs an operation. A write to operand 1 alone leaves the result words unchanged.
- R4: In unsigned multiply mode the result words hold the zero-extended 32-bit product, and the sum extension reads 0.
- R5: In signed multiply mode both operands are sign-extended. The high word is bits 31:16 of the signed product. The sum extension reads 0xFFFF when the product is negative and 0 otherwise.
- R6: A plain multiply clears both accumulators, so a following accumulate starts from its own product.
- R7: In unsigned accumulate mode each zero-extended product is added to the accumulator, the result words show its low 32 bits, and the sum extension reads 0.
- R8: In signed accumulate mode each sign-extended product is added to the 40-bit signed accumulator. The sum extension reads 0xFFFF when that full accumulator is negative and 0 otherwise, even when bit 31 of the result says otherwise.
- R9: A write to the low result word (BASE+0xA) seeds the accumulators. In unsigned modes the value is zero-extended; in signed modes it is sign-extended.
- R10: Odd addresses, offsets BASE+0x0 to 0x8 and addresses outside the 16-byte window read 0. Writes to the high result and sum-extension words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Byte address of the access |
| we | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |

## Verification
The operand-2 write is the place where two functions meet in one cycle. In that cycle the multiplier takes its operand straight from the bus, the adder consumes the accumulator, and the read path still shows the previous result. The bench provokes this by issuing writes back to back: a seed write followed at once by operand 2, and a mode change by operand 1 followed at once by operand 2. It also switches from a running sum to a plain multiply and back. A behavioural model built on wide integers is compared with the read data on every clock, and literal expected values at the corner points confirm the cycle in which each new result appears.

// File: rtl/mpy_pkg.sv
package mpy_pkg;

  // Mode code equals the operand-1 word index inside the window.
  typedef enum logic [1:0] {
    MD_UMUL = 2'd0,
    MD_SMUL = 2'd1,
    MD_UMAC = 2'd2,
    MD_SMAC = 2'd3
  } mpy_mode_e;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_LO   = 2'd1,
    RS_HI   = 2'd2,
    RS_EXT  = 2'd3
  } rd_sel_e;

  // Word indices (byte offset / 2) inside the 16-byte window.
  localparam logic [2:0] IDX_OP2 = 3'd4;
  localparam logic [2:0] IDX_LO  = 3'd5;
  localparam logic [2:0] IDX_HI  = 3'd6;
  localparam logic [2:0] IDX_EXT = 3'd7;

  function automatic logic mode_signed(input mpy_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_mac(input mpy_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/mpy_regdec.sv
module mpy_regdec
  import mpy_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0130
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output logic              op1_wr,
  output mpy_mode_e         op1_mode,
  output logic              op2_wr,
  output logic              lo_wr,
  output rd_sel_e           rd_sel
);

  localparam int WIN_LSB = 4;

  logic [2:0] idx;

  assign idx      = addr[WIN_LSB-1:1];
  assign hit      = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]) && !addr[0];
  assign op1_wr   = we && hit && !idx[2];
  assign op1_mode = mpy_mode_e'(idx[1:0]);
  assign op2_wr   = we && hit && (idx == IDX_OP2);
  assign lo_wr    = we && hit && (idx == IDX_LO);

  always_comb begin
    rd_sel = RS_NONE;
    if (hit) begin
      case (idx)
        IDX_LO:  rd_sel = RS_LO;
        IDX_HI:  rd_sel = RS_HI;
        IDX_EXT: rd_sel = RS_EXT;
        default: rd_sel = RS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mpy_prod.sv
module mpy_prod #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic                signed_mode,
  output logic [2*DATA_W-1:0] prod_lo,
  output logic [ACC_W-1:0]    prod_acc
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int FULL_W = PROD_W + 2;

  logic signed [DATA_W:0]   xa, xb;
  logic signed [FULL_W-1:0] wa, wb, full;

  // One extra bit turns both signednesses into one signed multiply.
  assign xa   = {signed_mode & op_a[DATA_W-1], op_a};
  assign xb   = {signed_mode & op_b[DATA_W-1], op_b};
  assign wa   = FULL_W'(xa);
  assign wb   = FULL_W'(xb);
  assign full = wa * wb;

  assign prod_lo = full[PROD_W-1:0];

  generate
    if (ACC_W > FULL_W) begin : g_wide
      assign prod_acc = {{(ACC_W-FULL_W){full[FULL_W-1]}}, full};
    end else begin : g_narrow
      assign prod_acc = full[ACC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/mpy_rdmux.sv
module mpy_rdmux
  import mpy_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rd_sel_e               sel,
  input  mpy_mode_e             mode,
  input  logic [2*DATA_W-1:0]   res_u,
  input  logic [2*DATA_W-1:0]   res_s,
  input  logic                  acc_neg,
  output logic [DATA_W-1:0]     rdata
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] res_view;

  assign res_view = mode_signed(mode) ? res_s : res_u;

  always_comb begin
    rdata = '0;
    case (sel)
      RS_LO: rdata = res_view[DATA_W-1:0];
      RS_HI: rdata = res_view[PROD_W-1:DATA_W];
      RS_EXT: begin
        case (mode)
          MD_SMUL: rdata = {DATA_W{res_s[PROD_W-1]}};
          MD_SMAC: rdata = {DATA_W{acc_neg}};
          default: rdata = '0;
        endcase
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mpy_mac_periph.sv
module mpy_mac_periph
  import mpy_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0130,
  parameter int              DATA_W = 16,
  parameter int              ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [ACC_W-1:0] zext_acc(input logic [DATA_W-1:0] v);
    return {{(ACC_W-DATA_W){1'b0}}, v};
  endfunction

  function automatic logic [ACC_W-1:0] sext_acc(input logic [DATA_W-1:0] v);
    return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  // Named internal events
  logic      hit, op1_wr, op2_wr, lo_wr;
  mpy_mode_e op1_mode;
  rd_sel_e   rd_sel;

  // State
  mpy_mode_e         mode_q;
  logic [DATA_W-1:0] op1_q;
  logic [ACC_W-1:0]  acc_u_q, acc_s_q;
  logic [PROD_W-1:0] res_u_q, res_s_q;

  logic [PROD_W-1:0] prod_lo;
  logic [ACC_W-1:0]  prod_acc, sum_u, sum_s, seed_z, seed_s;
  logic              fire_mac, fire_plain;

  mpy_regdec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr    (addr),
    .we      (we),
    .hit     (hit),
    .op1_wr  (op1_wr),
    .op1_mode(op1_mode),
    .op2_wr  (op2_wr),
    .lo_wr   (lo_wr),
    .rd_sel  (rd_sel)
  );

  mpy_prod #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_prod (
    .op_a       (op1_q),
    .op_b       (wdata),
    .signed_mode(mode_signed(mode_q)),
    .prod_lo    (prod_lo),
    .prod_acc   (prod_acc)
  );

  assign sum_u      = acc_u_q + prod_acc;
  assign sum_s      = acc_s_q + prod_acc;
  assign seed_z     = zext_acc(wdata);
  assign seed_s     = sext_acc(wdata);
  assign fire_mac   = op2_wr && mode_mac(mode_q);
  assign fire_plain = op2_wr && !mode_mac(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_UMUL;
      op1_q   <= '0;
      acc_u_q <= '0;
      acc_s_q <= '0;
      res_u_q <= '0;
      res_s_q <= '0;
    end else begin
      if (op1_wr) begin
        op1_q  <= wdata;
        mode_q <= op1_mode;
      end
      if (fire_plain) begin
        res_u_q <= prod_lo;
        res_s_q <= prod_lo;
        acc_u_q <= '0;
        acc_s_q <= '0;
      end else if (fire_mac) begin
        acc_u_q <= sum_u;
        acc_s_q <= sum_s;
        res_u_q <= sum_u[PROD_W-1:0];
        res_s_q <= sum_s[PROD_W-1:0];
      end else if (lo_wr) begin
        acc_u_q <= seed_z;
        acc_s_q <= seed_s;
        if (mode_signed(mode_q)) res_s_q <= seed_s[PROD_W-1:0];
        else                     res_u_q <= seed_z[PROD_W-1:0];
      end
    end
  end

  mpy_rdmux #(.DATA_W(DATA_W)) u_rd (
    .sel    (rd_sel),
    .mode   (mode_q),
    .res_u  (res_u_q),
    .res_s  (res_s_q),
    .acc_neg(acc_s_q[ACC_W-1]),
    .rdata  (rdata)
  );

  // Assertions
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_u_q == '0 && acc_s_q == '0 && res_u_q == '0 && res_s_q == '0));

  assert_mode_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op1_wr |=> (mode_q == $past(op1_mode) && op1_q == $past(wdata)));

  assert_op1_no_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op1_wr && !lo_wr && !op2_wr) |=> ($stable(res_u_q) && $stable(res_s_q)));

  assert_plain_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_plain |=> (acc_u_q == '0 && acc_s_q == '0));

  assert_mac_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_mac |=> (res_u_q == acc_u_q[PROD_W-1:0] && res_s_q == acc_s_q[PROD_W-1:0]));

  assert_umac_ext_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == RS_EXT && mode_q == MD_UMAC) |-> (rdata == '0));

  assert_seed_unsigned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !mode_signed(mode_q)) |=> (acc_u_q == zext_acc($past(wdata))));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || rd_sel == RS_NONE) |-> (rdata == '0));

endmodule

// File: tb/tb_mpy_mac_periph.sv
module tb_mpy_mac_periph;

  localparam int     ACCW     = 40;
  localparam longint ACC_MASK = (longint'(1) << ACCW) - 1;
  localparam longint W32_MASK = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state
  int     m_mode;
  longint m_op1, m_accu, m_accs, m_resu, m_ress;

  always #5 clk = ~clk;

  mpy_mac_periph dut (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr),
    .we   (we),
    .wdata(wdata),
    .rdata(rdata)
  );

  function automatic longint sx16(input longint v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic void m_write(input int a, input int d);
    longint pa, pb, p;
    if (a >= 'h130 && a <= 'h136 && (a % 2) == 0) begin
      m_op1  = d;
      m_mode = (a - 'h130) / 2;
    end else if (a == 'h138) begin
      pa = (m_mode % 2 == 1) ? sx16(m_op1) : m_op1;
      pb = (m_mode % 2 == 1) ? sx16(d) : longint'(d);
      p  = pa * pb;
      if (m_mode < 2) begin
        m_resu = p & W32_MASK;
        m_ress = p & W32_MASK;
        m_accu = 0;
        m_accs = 0;
      end else begin
        m_accu = (m_accu + p) & ACC_MASK;
        m_accs = (m_accs + p) & ACC_MASK;
        m_resu = m_accu & W32_MASK;
        m_ress = m_accs & W32_MASK;
      end
    end else if (a == 'h13A) begin
      m_accu = d;
      m_accs = sx16(d) & ACC_MASK;
      if (m_mode % 2 == 1) m_ress = sx16(d) & W32_MASK;
      else                 m_resu = d;
    end
  endfunction

  function automatic int m_read(input int a);
    longint r;
    r = (m_mode % 2 == 1) ? m_ress : m_resu;
    case (a)
      'h13A: return int'(r & 16'hFFFF);
      'h13C: return int'((r >> 16) & 16'hFFFF);
      'h13E: begin
        if (m_mode == 1) return ((m_ress >> 31) & 1) != 0 ? 'hFFFF : 0;
        if (m_mode == 3) return ((m_accs >> (ACCW-1)) & 1) != 0 ? 'hFFFF : 0;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_op1 = 0; m_accu = 0; m_accs = 0; m_resu = 0; m_ress = 0;
    end else if (we) begin
      m_write(int'(addr), int'(wdata));
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (int'(rdata) != m_read(int'(addr))) begin
        n_fail++;
        $display("FAIL %s model compare addr=%h: actual=%h expected=%h",
                 cur_req, addr, rdata, m_read(int'(addr)));
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; we = 1'b1;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #2;
    addr = a; we = 1'b0; wdata = 16'h0;
    @(negedge clk);
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read %h: actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    cur_req = "R1";
    expect_rd(16'h013A, 16'h0000, "R1");
    expect_rd(16'h013C, 16'h0000, "R1");
    expect_rd(16'h013E, 16'h0000, "R1");

    cur_req = "R4";
    wr(16'h0130, 16'hFFFF);
    wr(16'h0138, 16'hFFFF);
    expect_rd(16'h013A, 16'h0001, "R4");
    expect_rd(16'h013C, 16'hFFFE, "R4");
    expect_rd(16'h013E, 16'h0000, "R4");

    cur_req = "R5";
    wr(16'h0132, 16'hFFFF);
    wr(16'h0138, 16'h0003);
    expect_rd(16'h013A, 16'hFFFD, "R5");
    expect_rd(16'h013C, 16'hFFFF, "R5");
    expect_rd(16'h013E, 16'hFFFF, "R5");
    wr(16'h0132, 16'h8000);
    wr(16'h0138, 16'h8000);
    expect_rd(16'h013C, 16'h4000, "R5");
    expect_rd(16'h013E, 16'h0000, "R5");

    cur_req = "R7";
    wr(16'h0134, 16'hFFFF);
    wr(16'h0138, 16'hFFFF);
    wr(16'h0138, 16'hFFFF);
    expect_rd(16'h013A, 16'h0002, "R7");
    expect_rd(16'h013C, 16'hFFFC, "R7");
    expect_rd(16'h013E, 16'h0000, "R7");

    cur_req = "R3";
    wr(16'h0130, 16'h0002);
    expect_rd(16'h013A, 16'h0002, "R3");
    expect_rd(16'h013C, 16'hFFFC, "R3");

    cur_req = "R6";
    wr(16'h0138, 16'h0003);
    expect_rd(16'h013A, 16'h0006, "R6");
    wr(16'h0134, 16'h0010);
    wr(16'h0138, 16'h0010);
    expect_rd(16'h013A, 16'h0100, "R6");
    expect_rd(16'h013C, 16'h0000, "R6");

    cur_req = "R8";
    wr(16'h0136, 16'hFFFE);
    wr(16'h013A, 16'h0005);
    wr(16'h0138, 16'h0003);
    expect_rd(16'h013A, 16'hFFFF, "R8");
    expect_rd(16'h013C, 16'hFFFF, "R8");
    expect_rd(16'h013E, 16'hFFFF, "R8");
    wr(16'h0138, 16'hFFFD);
    expect_rd(16'h013A, 16'h0005, "R8");
    expect_rd(16'h013E, 16'h0000, "R8");

    cur_req = "R9";
    wr(16'h013A, 16'h8000);
    expect_rd(16'h013A, 16'h8000, "R9");
    expect_rd(16'h013C, 16'hFFFF, "R9");
    expect_rd(16'h013E, 16'hFFFF, "R9");
    wr(16'h0134, 16'h0001);
    wr(16'h013A, 16'h8000);
    expect_rd(16'h013C, 16'h0000, "R9");
    wr(16'h0138, 16'h0001);
    expect_rd(16'h013A, 16'h8001, "R9");

    cur_req = "R8";
    wr(16'h0136, 16'h8000);
    wr(16'h013A, 16'h0000);
    wr(16'h0138, 16'h8000);
    wr(16'h0138, 16'h8000);
    expect_rd(16'h013A, 16'h0000, "R8");
    expect_rd(16'h013C, 16'h8000, "R8");
    expect_rd(16'h013E, 16'h0000, "R8");

    cur_req = "R10";
    for (int i = 0; i < 5; i++) expect_rd(16'h0130 + 16'(2 * i), 16'h0000, "R10");
    expect_rd(16'h013B, 16'h0000, "R10");
    expect_rd(16'h0140, 16'h0000, "R10");
    expect_rd(16'h012E, 16'h0000, "R10");
    wr(16'h013C, 16'h1234);
    wr(16'h013E, 16'h5678);
    wr(16'h014A, 16'h0011);
    expect_rd(16'h013A, 16'h0000, "R10");
    expect_rd(16'h013C, 16'h8000, "R10");
    expect_rd(16'h013E, 16'h0000, "R10");

    cur_req = "R2";
    wr(16'h0132, 16'h0007);
    wr(16'h0138, 16'hFFFF);
    expect_rd(16'h013A, 16'hFFF9, "R2");
    expect_rd(16'h013E, 16'hFFFF, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule